// File: doc/BRIEF.md
# Programmable Flag GPIO Controller

This block drives and senses a bank of sixteen bidirectional flag pins. Each pin has its own direction bit. Software can load the whole output value at once, or change chosen pins through set, clear and toggle aliases. Writing a 1 through an alias acts on that pin, and writing a 0 leaves it alone, so no read-modify-write is needed. A status read returns the level of every pin as the controller sees it. For an input pin this is the synchronised pad level. For an output pin it is the driven value.

Each pin can raise the shared interrupt. Enables are switched on and off through separate write-one aliases. A per-pin sense bit picks level mode or edge mode. In edge mode a second bit picks rising edges only or both edges, and a detected edge is held in a per-pin pending latch. Each latch is a two-state machine: idle (EL_IDLE) goes to pending (EL_PEND) on a qualifying edge, and pending goes back to idle when software writes 1 to that pin's clear alias. If an edge arrives in the same cycle as the clear, the latch stays pending. Inputs pass through a two-flop synchroniser before any edge or level logic sees them. An output pin's sensed level follows the driven value, so a software change on an output pin can raise an interrupt.

The register bus is a one-cycle write strobe with a combinational read port. Register codes are: 0 value (write loads the outputs, read gives status), 1 set, 2 clear, 3 toggle, 4 direction, 5 enable-set, 6 enable-clear, 7 sense, 8 edge-both and 9 pending (read only). Codes 1 and 5 read back the output latch and the enable mask. Code 6 also reads the enable mask. Code 2 reads back the output latch, because writes to it clear outputs as well as pending latches. Code 3 reads as 0, and so do the unused codes 10 to 15.

Top module: `pfg_top`

## Requirements
- R1: After reset, pad_out, pad_oe, irq and every configuration register read back 0.
- R2: A write to code 0 loads the output latch, and pad_out shows it on the next cycle. pad_oe equals the direction register, where 1 means output.
- R3: A write to code 1 sets the output bits written as 1 and leaves the others unchanged.
- R4: A write to code 2 clears the output bits written as 1 and leaves the others unchanged.
- R5: A write to code 3 inverts the output bits written as 1 and leaves the others unchanged.
- R6: Reading code 0 returns, per pin, the output latch for output pins and the pad level for input pins. A pad change shows after two clock edges.
- R7: A write to code 5 turns on the enables written as 1. A write to code 6 turns off the enables written as 1. Code 5 reads back the mask.
- R8: A level-mode pin (sense bit 0) that is enabled and high asserts irq. irq drops again when the level falls.
- R9: An edge-mode pin with edge-both bit 0 latches a rising edge as pending (code 9) and ignores a falling edge.
- R10: An edge-mode pin with edge-both bit 1 also latches a falling edge.
- R11: Writing 1 to code 2 clears that pin's pending latch. Pins written as 0 stay pending.
- R12: An output pin in edge mode latches an edge caused by a software write to its output value, and raises irq when enabled.
- R13: A pin whose enable is 0 never asserts irq, even when it is high or pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 4 | Register code |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| pad_in | input | 16 | Pad input levels |
| pad_out | output | 16 | Driven output values |
| pad_oe | output | 16 | Output enable per pin |
| irq | output | 1 | Registered interrupt request |

## Verification
The output aliases are tried on a mixed pattern, 0xA5A5, with set, clear and toggle masks that overlap both ones and zeros. This shows that bits written as 0 are left alone. The status read uses a split direction with different data on each half, which shows whether each pin reports the pad or the latch. The interrupt path is driven by a single pin rising and then falling, first in level mode, then rising-only, then both-edge. This separates a held level from a latched edge and shows which edges are counted. Software-driven output edges and edges on disabled pins show that a latch can be pending without raising irq, and that irq follows the enable mask.

// File: rtl/pfg_pkg.sv
package pfg_pkg;

    localparam int unsigned ADDR_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        RA_VALUE   = 4'd0,
        RA_SET     = 4'd1,
        RA_CLR     = 4'd2,
        RA_TGL     = 4'd3,
        RA_DIR     = 4'd4,
        RA_IEN_SET = 4'd5,
        RA_IEN_CLR = 4'd6,
        RA_SENSE   = 4'd7,
        RA_BOTH    = 4'd8,
        RA_PEND    = 4'd9
    } reg_addr_e;

    typedef enum logic {
        EL_IDLE = 1'b0,
        EL_PEND = 1'b1
    } latch_st_e;

endpackage

// File: rtl/pfg_sync.sv
module pfg_sync #(
    parameter int unsigned W      = 16,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/pfg_regs.sv
module pfg_regs
    import pfg_pkg::*;
#(
    parameter int unsigned NPINS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  out_q,
    output logic [NPINS-1:0]  dir_q,
    output logic [NPINS-1:0]  ien_q,
    output logic [NPINS-1:0]  sense_q,
    output logic [NPINS-1:0]  both_q,
    output logic [NPINS-1:0]  clr_pulse
);

    reg_addr_e sel;
    assign sel = reg_addr_e'(bus_addr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q   <= '0;
            dir_q   <= '0;
            ien_q   <= '0;
            sense_q <= '0;
            both_q  <= '0;
        end else if (bus_wr) begin
            unique case (sel)
                RA_VALUE:   out_q   <= bus_wdata;
                RA_SET:     out_q   <= out_q | bus_wdata;
                RA_CLR:     out_q   <= out_q & ~bus_wdata;
                RA_TGL:     out_q   <= out_q ^ bus_wdata;
                RA_DIR:     dir_q   <= bus_wdata;
                RA_IEN_SET: ien_q   <= ien_q | bus_wdata;
                RA_IEN_CLR: ien_q   <= ien_q & ~bus_wdata;
                RA_SENSE:   sense_q <= bus_wdata;
                RA_BOTH:    both_q  <= bus_wdata;
                default:    ;
            endcase
        end
    end

    always_comb begin
        clr_pulse = '0;
        if (bus_wr && (sel == RA_CLR)) clr_pulse = bus_wdata;
    end

    // R3: ones written through the set alias end up high, other bits keep their value
    p_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && sel == RA_SET) |=>
            (((out_q & $past(bus_wdata)) == $past(bus_wdata)) &&
             ((out_q & ~$past(bus_wdata)) == ($past(out_q) & ~$past(bus_wdata)))));

    // R4: ones written through the clear alias end up low, other bits keep their value
    p_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && sel == RA_CLR) |=>
            (((out_q & $past(bus_wdata)) == '0) &&
             ((out_q & ~$past(bus_wdata)) == ($past(out_q) & ~$past(bus_wdata)))));

    // R5: toggled bits flip, every other bit holds
    p_tgl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && sel == RA_TGL) |=> ((out_q ^ $past(out_q)) == $past(bus_wdata)));

    // R7: enable-set turns bits on and never turns any off
    p_ien_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && sel == RA_IEN_SET) |=>
            (((ien_q & $past(bus_wdata)) == $past(bus_wdata)) &&
             ((ien_q & $past(ien_q)) == $past(ien_q))));

endmodule

// File: rtl/pfg_edge.sv
module pfg_edge
    import pfg_pkg::*;
#(
    parameter int unsigned NPINS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] sensed_i,
    input  logic [NPINS-1:0] sense_i,
    input  logic [NPINS-1:0] both_i,
    input  logic [NPINS-1:0] ien_i,
    input  logic [NPINS-1:0] clr_i,
    output logic [NPINS-1:0] pend_o,
    output logic             irq_o
);

    logic [NPINS-1:0] prev_q;
    logic [NPINS-1:0] rise;
    logic [NPINS-1:0] fall;
    logic [NPINS-1:0] hit;
    logic [NPINS-1:0] active;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= sensed_i;
    end

    assign rise = sensed_i & ~prev_q;
    assign fall = ~sensed_i & prev_q;
    assign hit  = sense_i & (rise | (both_i & fall));

    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        latch_st_e st_q, st_d;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st_q <= EL_IDLE;
            else        st_q <= st_d;
        end

        always_comb begin
            st_d = st_q;
            unique case (st_q)
                EL_IDLE: if (hit[g])               st_d = EL_PEND;
                EL_PEND: if (clr_i[g] && !hit[g])  st_d = EL_IDLE;
                default:                           st_d = EL_IDLE;
            endcase
        end

        assign pend_o[g] = (st_q == EL_PEND);
    end

    assign active = (sense_i & pend_o) | (~sense_i & sensed_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= |(ien_i & active);
    end

    // R13: with every enable off, the interrupt stays low
    p_irq_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_i == '0) |=> !irq_o);

    // R11: a clear with no competing edge empties the pending latch
    p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_i & ~hit) != '0) |=> ((pend_o & $past(clr_i & ~hit)) == '0));

    // R9: a qualifying edge is always captured by the latch
    p_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (hit != '0) |=> ((pend_o & $past(hit)) == $past(hit)));

    // R8: an enabled level-mode pin that is high raises irq on the next edge
    p_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((ien_i & ~sense_i & sensed_i) != '0) |=> irq_o);

endmodule

// File: rtl/pfg_top.sv
module pfg_top
    import pfg_pkg::*;
#(
    parameter int unsigned NPINS       = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe,
    output logic              irq
);

    logic [NPINS-1:0] pad_sync;
    logic [NPINS-1:0] out_q, dir_q, ien_q, sense_q, both_q, clr_pulse;
    logic [NPINS-1:0] sensed;
    logic [NPINS-1:0] pend;

    pfg_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pad_in),
        .q_o   (pad_sync)
    );

    pfg_regs #(.NPINS(NPINS)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .out_q     (out_q),
        .dir_q     (dir_q),
        .ien_q     (ien_q),
        .sense_q   (sense_q),
        .both_q    (both_q),
        .clr_pulse (clr_pulse)
    );

    assign sensed = (dir_q & out_q) | (~dir_q & pad_sync);

    pfg_edge #(.NPINS(NPINS)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .sensed_i (sensed),
        .sense_i  (sense_q),
        .both_i   (both_q),
        .ien_i    (ien_q),
        .clr_i    (clr_pulse),
        .pend_o   (pend),
        .irq_o    (irq)
    );

    assign pad_out = out_q;
    assign pad_oe  = dir_q;

    always_comb begin
        bus_rdata = '0;
        case (reg_addr_e'(bus_addr))
            RA_VALUE:   bus_rdata = sensed;
            RA_SET:     bus_rdata = out_q;
            RA_CLR:     bus_rdata = out_q;
            RA_DIR:     bus_rdata = dir_q;
            RA_IEN_SET: bus_rdata = ien_q;
            RA_IEN_CLR: bus_rdata = ien_q;
            RA_SENSE:   bus_rdata = sense_q;
            RA_BOTH:    bus_rdata = both_q;
            RA_PEND:    bus_rdata = pend;
            default:    bus_rdata = '0;
        endcase
    end

    // R2: the pad enable always mirrors the direction register
    p_oe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == RA_DIR) |=> (pad_oe == $past(bus_wdata)));

endmodule

// File: tb/pfg_top_tb.sv
module pfg_top_tb;

    localparam int NPINS = 16;

    typedef struct {
        string       tag;
        int          kind;
        logic [15:0] exp;
    } sb_item_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             bus_wr = 1'b0;
    logic [3:0]       bus_addr = '0;
    logic [NPINS-1:0] bus_wdata = '0;
    logic [NPINS-1:0] bus_rdata;
    logic [NPINS-1:0] pad_in = '0;
    logic [NPINS-1:0] pad_out;
    logic [NPINS-1:0] pad_oe;
    logic             irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    sb_item_t sb_q[$];

    always #5 clk = ~clk;

    pfg_top u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pad_in    (pad_in),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe),
        .irq       (irq)
    );

    // monitor: pops one expected item per falling edge and compares
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            sb_item_t it;
            logic [15:0] act;
            it = sb_q.pop_front();
            case (it.kind)
                0:       act = bus_rdata;
                1:       act = pad_out;
                2:       act = pad_oe;
                default: act = {15'd0, irq};
            endcase
            checks++;
            if (act !== it.exp) begin
                fails++;
                $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
            end
        end
    end

    task automatic expect_val(input int kind, input logic [3:0] addr,
                              input logic [15:0] exp, input string tag);
        sb_item_t it;
        if (kind == 0) bus_addr = addr;
        it.tag = tag; it.kind = kind; it.exp = exp;
        sb_q.push_back(it);
        wait (sb_q.size() == 0);
    endtask

    task automatic wr(input logic [3:0] addr, input logic [15:0] data);
        @(posedge clk); #1;
        bus_wr = 1'b1; bus_addr = addr; bus_wdata = data;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        expect_val(1, 0, 16'h0000, "R1 pad_out");
        expect_val(2, 0, 16'h0000, "R1 pad_oe");
        expect_val(3, 0, 16'h0000, "R1 irq");
        expect_val(0, 4, 16'h0000, "R1 dir");
        expect_val(0, 5, 16'h0000, "R1 ien");

        // R2..R5 output aliases
        wr(4, 16'hFFFF);
        wr(0, 16'hA5A5);
        expect_val(1, 0, 16'hA5A5, "R2 direct value");
        expect_val(2, 0, 16'hFFFF, "R2 oe from dir");
        wr(1, 16'h0F00);
        expect_val(1, 0, 16'hAFA5, "R3 set alias");
        wr(2, 16'h00A0);
        expect_val(1, 0, 16'hAF05, "R4 clear alias");
        wr(3, 16'hFF00);
        expect_val(1, 0, 16'h5005, "R5 toggle alias");

        // R6 status: high byte inputs, low byte outputs
        wr(4, 16'h00FF);
        pad_in = 16'h1234;
        tick(4);
        expect_val(0, 0, 16'h1205, "R6 status mix");

        // cleanup
        pad_in = '0;
        wr(0, 16'h0000);
        wr(2, 16'hFFFF);
        tick(3);
        expect_val(0, 9, 16'h0000, "R11 pending empty");

        // R7 enables
        wr(4, 16'h0000);
        wr(5, 16'h00F0);
        wr(5, 16'h0003);
        wr(6, 16'h0030);
        expect_val(0, 5, 16'h00C3, "R7 enable mask");
        tick(2);
        expect_val(3, 0, 16'h0000, "R8 irq idle");

        // R8 level mode
        pad_in = 16'h0040;
        tick(5);
        expect_val(3, 0, 16'h0001, "R8 level high irq");
        expect_val(0, 0, 16'h0040, "R6 status input");
        pad_in = 16'h0000;
        tick(5);
        expect_val(3, 0, 16'h0000, "R8 level low irq");
        pad_in = 16'h0020;
        tick(5);
        expect_val(3, 0, 16'h0000, "R13 disabled level");
        pad_in = 16'h0000;
        tick(3);

        // R9 rising only on pin 7
        wr(7, 16'h0080);
        wr(8, 16'h0000);
        pad_in = 16'h0080;
        tick(5);
        expect_val(3, 0, 16'h0001, "R9 rising irq");
        expect_val(0, 9, 16'h0080, "R9 rising pending");
        wr(2, 16'h0080);
        tick(3);
        expect_val(0, 9, 16'h0000, "R11 cleared");
        expect_val(3, 0, 16'h0000, "R11 irq gone");
        pad_in = 16'h0000;
        tick(5);
        expect_val(0, 9, 16'h0000, "R9 falling ignored");

        // R10 both edges
        wr(8, 16'h0080);
        pad_in = 16'h0080;
        tick(5);
        expect_val(0, 9, 16'h0080, "R10 rising latched");
        wr(2, 16'h0080);
        tick(3);
        pad_in = 16'h0000;
        tick(5);
        expect_val(0, 9, 16'h0080, "R10 falling latched");
        expect_val(3, 0, 16'h0001, "R10 irq");
        wr(2, 16'h0040);
        tick(3);
        expect_val(0, 9, 16'h0080, "R11 zero bit keeps");
        wr(2, 16'h0080);
        tick(3);
        expect_val(0, 9, 16'h0000, "R11 one bit clears");

        // R12 software edge on output pin 0
        wr(4, 16'h0001);
        wr(7, 16'h0081);
        wr(1, 16'h0001);
        tick(3);
        expect_val(1, 0, 16'h0001, "R12 pad driven");
        expect_val(0, 9, 16'h0001, "R12 pending");
        expect_val(3, 0, 16'h0001, "R12 irq");
        wr(2, 16'h0001);
        tick(3);
        expect_val(0, 9, 16'h0000, "R12 falling not latched");
        expect_val(3, 0, 16'h0000, "R12 irq cleared");

        // R13 pending on a disabled pin
        wr(7, 16'h0085);
        pad_in = 16'h0004;
        tick(5);
        expect_val(0, 9, 16'h0004, "R13 pending held");
        expect_val(3, 0, 16'h0000, "R13 irq masked");

        done = 1'b1;
        summary();
        $finish;
    end

endmodule